// File: doc/BRIEF.md
# Event Readout Word Packer with Output FIFO

This block collects the digitised results of every converter on a detector card once the central trigger asks for an event readout. Starting from converter 0, it checks each converter in turn. A converter marked as suppressed (empty, or outside its digital window) is passed over. Every other converter produces one 32-bit event word, and that word is pushed into an on-chip FIFO. The host bus drains the FIFO from the other side.

Each event word holds three things: the converter's two pileup qualifier bits, a 14-bit identifier that software writes for that converter, and the 14-bit conversion result. The identifier bank can be written and read back at any time. A separate diagnostic port returns the present result of any single converter, chosen by its index, without starting a scan.

If the FIFO fills during a scan, the scan waits on the current converter until the host frees a slot, so no word is lost. A one-cycle completion pulse marks the end of each scan.

Top module: `evpk_top`

## Requirements
- R1: Every event word has the form [31:30] qualifier bits, [29:16] identifier of that converter, [15:14] zero, [13:0] conversion result. Converter k takes its result from adc_data_i[14k+13:14k] and its qualifier from adc_qual_i[2k+1:2k].
- R2: A converter whose adc_drop_i bit is 1 produces no word. A converter whose bit is 0 produces exactly one word per scan.
- R3: Within a scan, words enter the FIFO in ascending converter index. The scan visits one converter per clock cycle unless it is stalled.
- R4: A scan starts only on a cycle in which rdo_req_i is high while the block is idle. A request that arrives during a scan has no effect. While idle, the FIFO receives nothing.
- R5: While the FIFO is full, the scan holds on the current non-suppressed converter and writes nothing. It then continues without losing or duplicating a word.
- R6: scan_done_o is high for exactly one cycle, the cycle that handles the last converter. With no stall, this is the NUM_ADC-th cycle after scan_busy_o rises. scan_busy_o is low in the following cycle.
- R7: Writing value v to identifier address a (a < NUM_ADC) makes id_rd_data_o return v for address a. Converter a's later words then carry v.
- R8: diag_data_o always equals the present result of the converter selected by diag_sel_i.
- R9: The FIFO is first-in first-out. fifo_data_o shows the oldest word while fifo_empty_o is low. A read while the FIFO is empty has no effect.
- R10: After reset, the FIFO is empty, the block is idle, and every identifier reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdo_req_i | input | 1 | Readout request from the trigger system |
| adc_data_i | input | NUM_ADC*14 | Conversion results, converter k in bits 14k+13:14k |
| adc_qual_i | input | NUM_ADC*2 | Pileup qualifier pairs, converter k in bits 2k+1:2k |
| adc_drop_i | input | NUM_ADC | 1 marks a converter as suppressed |
| id_wr_en_i | input | 1 | Identifier write strobe |
| id_wr_addr_i | input | ADDR_W | Identifier write index |
| id_wr_data_i | input | 14 | Identifier write value |
| id_rd_addr_i | input | ADDR_W | Identifier read-back index |
| id_rd_data_o | output | 14 | Identifier read-back value |
| diag_sel_i | input | ADDR_W | Diagnostic converter index |
| diag_data_o | output | 14 | Selected converter's present result |
| fifo_rd_i | input | 1 | Host pop strobe |
| fifo_data_o | output | 32 | Oldest FIFO word |
| fifo_empty_o | output | 1 | FIFO holds no word |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH words |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The assertions assume three things about the inputs. The converter results, qualifiers and suppression flags stay steady from the request until the completion pulse. Identifier writes use indices below NUM_ADC while a check depends on them. The host pops only words it has sampled.

The stimulus follows these rules. It changes data and flags only between scans. It writes every identifier before the first scan. It drives the pop strobe at the falling edge, from the empty flag it has just sampled.

Within those limits, the bench varies the suppression masks (none, all, alternating, only the end converters) and tests a full-FIFO stall combined with a repeated request.

// File: rtl/evpk_pkg.sv
package evpk_pkg;
  localparam int QUAL_W = 2;
  localparam int ID_W   = 14;
  localparam int DATA_W = 14;
  localparam int WORD_W = 32;

  // Builds one event word: qualifier, identifier, two zero bits, result.
  function automatic logic [WORD_W-1:0] pack_word(
    input logic [QUAL_W-1:0] qual,
    input logic [ID_W-1:0]   id,
    input logic [DATA_W-1:0] data
  );
    return {qual, id, 2'b00, data};
  endfunction
endpackage

// File: rtl/evpk_id_bank.sv
module evpk_id_bank
  import evpk_pkg::*;
#(
  parameter int NUM    = 20,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ID_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ID_W-1:0]   rd_data_o,
  input  logic [ADDR_W-1:0] scan_idx_i,
  output logic [ID_W-1:0]   scan_id_o
);
  logic [ID_W-1:0] id_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        id_q[g] <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(g)))
        id_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < NUM) rd_data_o = id_q[rd_addr_i];
    scan_id_o = '0;
    if (int'(scan_idx_i) < NUM) scan_id_o = id_q[scan_idx_i];
  end

  AST_ID_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(wr_addr_i) < NUM) |=> id_q[$past(wr_addr_i)] == $past(wr_data_i)); // R7
endmodule

// File: rtl/evpk_scan.sv
module evpk_scan #(
  parameter int NUM    = 20,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [NUM-1:0]    drop_i,
  input  logic              fifo_full_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM - 1);

  logic              busy_q;
  logic [ADDR_W-1:0] idx_q;
  logic              cur_drop, stall, adv;

  always_comb begin
    cur_drop = drop_i[idx_q];
    stall    = busy_q && !cur_drop && fifo_full_i;
    adv      = busy_q && !stall;
    push_o   = busy_q && !cur_drop && !fifo_full_i;
    done_o   = adv && (idx_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (adv) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + ADDR_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !done_o) |=> (busy_q && idx_q == $past(idx_q) + ADDR_W'(1))); // R3
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !req_i) |=> !busy_q); // R4
  AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !push_o); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (busy_q && $stable(idx_q))); // R5
  AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_q && !done_o)); // R6
endmodule

// File: rtl/evpk_fifo.sv
module evpk_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !push_i) |=> empty_o); // R9
endmodule

// File: rtl/evpk_top.sv
module evpk_top
  import evpk_pkg::*;
#(
  parameter  int NUM_ADC    = 20,
  parameter  int FIFO_DEPTH = 8,
  localparam int ADDR_W     = $clog2(NUM_ADC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rdo_req_i,
  input  logic [NUM_ADC*DATA_W-1:0]   adc_data_i,
  input  logic [NUM_ADC*QUAL_W-1:0]   adc_qual_i,
  input  logic [NUM_ADC-1:0]          adc_drop_i,
  input  logic                        id_wr_en_i,
  input  logic [ADDR_W-1:0]           id_wr_addr_i,
  input  logic [ID_W-1:0]             id_wr_data_i,
  input  logic [ADDR_W-1:0]           id_rd_addr_i,
  output logic [ID_W-1:0]             id_rd_data_o,
  input  logic [ADDR_W-1:0]           diag_sel_i,
  output logic [DATA_W-1:0]           diag_data_o,
  input  logic                        fifo_rd_i,
  output logic [WORD_W-1:0]           fifo_data_o,
  output logic                        fifo_empty_o,
  output logic                        fifo_full_o,
  output logic                        scan_busy_o,
  output logic                        scan_done_o
);
  // Named internal events shared with the assertions.
  logic              scan_push;
  logic [ADDR_W-1:0] scan_idx;
  logic [ID_W-1:0]   scan_id;
  logic [WORD_W-1:0] scan_word;
  logic [DATA_W-1:0] cur_data;
  logic [QUAL_W-1:0] cur_qual;

  evpk_id_bank #(.NUM(NUM_ADC), .ADDR_W(ADDR_W)) id_bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(id_wr_en_i), .wr_addr_i(id_wr_addr_i), .wr_data_i(id_wr_data_i),
    .rd_addr_i(id_rd_addr_i), .rd_data_o(id_rd_data_o),
    .scan_idx_i(scan_idx), .scan_id_o(scan_id)
  );

  evpk_scan #(.NUM(NUM_ADC), .ADDR_W(ADDR_W)) scan_i (
    .clk(clk), .rst_n(rst_n), .req_i(rdo_req_i), .drop_i(adc_drop_i),
    .fifo_full_i(fifo_full_o), .busy_o(scan_busy_o), .done_o(scan_done_o),
    .push_o(scan_push), .idx_o(scan_idx)
  );

  always_comb begin
    cur_data    = adc_data_i[DATA_W*int'(scan_idx) +: DATA_W];
    cur_qual    = adc_qual_i[QUAL_W*int'(scan_idx) +: QUAL_W];
    scan_word   = pack_word(cur_qual, scan_id, cur_data);
    diag_data_o = '0;
    if (int'(diag_sel_i) < NUM_ADC)
      diag_data_o = adc_data_i[DATA_W*int'(diag_sel_i) +: DATA_W];
  end

  evpk_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(scan_push), .din_i(scan_word),
    .pop_i(fifo_rd_i), .dout_o(fifo_data_o),
    .empty_o(fifo_empty_o), .full_o(fifo_full_o)
  );

  AST_WORD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    scan_push |-> (scan_word[15:14] == 2'b00 && scan_word[13:0] == cur_data)); // R1
  AST_DROP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy_o && adc_drop_i[scan_idx]) |-> !scan_push); // R2
endmodule

// File: tb/evpk_top_tb_top.sv
module evpk_top_tb_top;
  localparam int N  = 20;
  localparam int AW = $clog2(N);
  localparam int NV = 5;

  // Stimulus vectors: suppression mask, result seed, qualifier seed.
  localparam logic [N-1:0] VEC_DROP [NV] = '{20'h00000, 20'hFFFFF, 20'hAAAAA, 20'h7FFFE, 20'h0F0F3};
  localparam logic [13:0]  VEC_BASE [NV] = '{14'h0123, 14'h3FFF, 14'h2000, 14'h0001, 14'h1555};
  localparam logic [1:0]   VEC_QS   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdo_req = 1'b0;
  logic [N*14-1:0] adc_data = '0;
  logic [N*2-1:0]  adc_qual = '0;
  logic [N-1:0]    adc_drop = '0;
  logic            id_wr_en = 1'b0;
  logic [AW-1:0]   id_wr_addr = '0, id_rd_addr = '0, diag_sel = '0;
  logic [13:0]     id_wr_data = '0;
  logic [13:0]     id_rd_data, diag_data;
  logic            fifo_rd = 1'b0;
  logic [31:0]     fifo_data;
  logic            fifo_empty, fifo_full, scan_busy, scan_done;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] exp_w [N];
  int          exp_n;

  always #10 clk = ~clk;

  evpk_top dut_i (
    .clk(clk), .rst_n(rst_n), .rdo_req_i(rdo_req),
    .adc_data_i(adc_data), .adc_qual_i(adc_qual), .adc_drop_i(adc_drop),
    .id_wr_en_i(id_wr_en), .id_wr_addr_i(id_wr_addr), .id_wr_data_i(id_wr_data),
    .id_rd_addr_i(id_rd_addr), .id_rd_data_o(id_rd_data),
    .diag_sel_i(diag_sel), .diag_data_o(diag_data),
    .fifo_rd_i(fifo_rd), .fifo_data_o(fifo_data),
    .fifo_empty_o(fifo_empty), .fifo_full_o(fifo_full),
    .scan_busy_o(scan_busy), .scan_done_o(scan_done)
  );

  function automatic logic [13:0] id_of(int i);
    return 14'(i * 771 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FIL_%s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Loads inputs and builds the expected word list in ascending index order.
  task automatic load_vec(input logic [N-1:0] drop, input logic [13:0] base, input logic [1:0] qs);
    exp_n = 0;
    for (int i = 0; i < N; i++) begin
      logic [13:0] d;
      logic [1:0]  q;
      d = 14'(int'(base) + i * 613);
      q = 2'(int'(qs) + i);
      adc_data[i*14 +: 14] = d;
      adc_qual[i*2 +: 2]   = q;
      if (!drop[i]) begin
        exp_w[exp_n] = {q, id_of(i), 2'b00, d};
        exp_n++;
      end
    end
    adc_drop = drop;
  endtask

  task automatic start_scan();
    @(negedge clk) rdo_req = 1'b1;
    @(negedge clk) rdo_req = 1'b0;
  endtask

  // Drains while the scan runs; checks order, content, count and done timing.
  task automatic drain(input int done_at, input string tag);
    int k = 0, cyc = 0, dones = 0, done_cyc = -1;
    bit fin = 0;
    while (!fin && cyc < 400) begin
      if (dones > 0 && fifo_empty) fin = 1;
      if (scan_done) begin dones++; done_cyc = cyc; end
      if (!fifo_empty) begin
        check(k < exp_n && fifo_data == exp_w[k], tag, fifo_data, (k < exp_n) ? exp_w[k] : 32'hX);
        k++;
        fifo_rd = 1'b1;
      end else begin
        fifo_rd = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    fifo_rd = 1'b0;
    check(k == exp_n, "R2", 32'(k), 32'(exp_n));
    check(dones == 1, "R6", 32'(dones), 32'd1);
    if (done_at >= 0) check(done_cyc == done_at, "R6", 32'(done_cyc), 32'(done_at));
    check(!scan_busy, "R6", {31'd0, scan_busy}, 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(fifo_empty && !scan_busy && !scan_done, "R10", {29'd0, fifo_empty, scan_busy, scan_done}, 32'h4);
    id_rd_addr = AW'(7);
    #1 check(id_rd_data == 14'd0, "R10", 32'(id_rd_data), 32'd0);

    // R7 identifier write and read-back
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      id_wr_en = 1'b1; id_wr_addr = AW'(i); id_wr_data = id_of(i);
    end
    @(negedge clk) id_wr_en = 1'b0;
    for (int i = 0; i < N; i++) begin
      id_rd_addr = AW'(i);
      #1 check(id_rd_data == id_of(i), "R7", 32'(id_rd_data), 32'(id_of(i)));
    end

    // R8 diagnostic read
    load_vec(20'h0, 14'h0ABC, 2'd0);
    for (int i = 0; i < N; i += 3) begin
      diag_sel = AW'(i);
      #1 check(diag_data == 14'(14'h0ABC + i * 613), "R8", 32'(diag_data), 32'(14'(14'h0ABC + i * 613)));
    end

    // R4 no scan without a request; R9 pop while empty is harmless
    @(negedge clk) fifo_rd = 1'b1;
    repeat (6) @(negedge clk);
    fifo_rd = 1'b0;
    check(fifo_empty && !scan_busy, "R4", {30'd0, fifo_empty, scan_busy}, 32'h2);

    // R1 R2 R3 R6 R9 table of vectors
    for (int v = 0; v < NV; v++) begin
      load_vec(VEC_DROP[v], VEC_BASE[v], VEC_QS[v]);
      start_scan();
      drain(N - 1, "R1");
    end

    // R5 full stall, with R4 repeated request ignored
    load_vec(20'h0, 14'h1234, 2'd2);
    start_scan();
    repeat (15) @(negedge clk);
    rdo_req = 1'b1;
    @(negedge clk) rdo_req = 1'b0;
    repeat (10) @(negedge clk);
    check(fifo_full && scan_busy && !scan_done, "R5", {29'd0, fifo_full, scan_busy, scan_done}, 32'h6);
    drain(-1, "R5");
    repeat (5) @(negedge clk);
    check(fifo_empty && !scan_busy, "R4", {30'd0, fifo_empty, scan_busy}, 32'h2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule